// File: doc/BRIEF.md
# Micro-Sequenced Accumulator Core

This block is a small processor core with one general register. A sequencer runs each instruction as a fixed series of clock time units. Each time unit carries one group of register transfers that do not conflict with each other. A 2-bit cycle code records which phase the core is in: fetch, indirect, execute or interrupt. The core keeps a program counter, a memory address register, a memory buffer register, an instruction register and the accumulator. It reaches a single-port word memory through an address, a read strobe, a write strobe, write data and read data. The memory answers a read one cycle after the strobe.

An instruction word is 16 bits wide. Bits 15..13 hold the opcode, bit 12 is the indirect flag and bits 11..0 are the address. The operations are add-to-accumulator, increment-and-skip-if-zero, branch-and-save-return-address and halt. There is one interrupt request line, gated by an enable flag. When an interrupt is taken, the core saves the return address at a fixed slot in memory and jumps to a fixed service address.

Top module: `uop_core`

## Requirements
- R1: A synchronous active-low reset clears the memory address register, the buffer register, the instruction register, the accumulator, the interrupt enable and the halted flag. It sets the program counter to 2 and the cycle code to 00 (fetch). No memory strobe is active while reset is low.
- R2: The cycle code port shows 00 for fetch, 01 for indirect, 10 for execute and 11 for interrupt. Fetch takes three time units and adds one to the program counter. Only execute ever lasts four units.
- R3: If bit 12 of the fetched word is set, a three-unit indirect cycle follows fetch. It reads the word at the address field and replaces the address field of the instruction register with bits 11..0 of that word. Execute always follows indirect.
- R4: Opcode 0 (add) takes three execute units and sets the accumulator to its old value plus the operand word, modulo 2^16.
- R5: Opcode 1 (increment-and-skip) takes four execute units. It writes the operand plus one back to the same address in the fourth unit. In that same unit the program counter advances by one more when the written value is zero.
- R6: Opcode 2 (branch-and-save) takes three execute units. It writes the address of the next instruction to the operand address, and execution continues at the operand address plus one.
- R7: Opcode 7 (halt) raises the halted output after one execute unit. From then until reset the program counter, the accumulator and the cycle code do not change, and no memory strobe is issued.
- R8: An interrupt is taken only at the end of an execute cycle, and only while the request input is high and the enable flag is set. The three-unit interrupt cycle (code 11) writes the saved program counter to address 0 and then resumes fetching at address 1.
- R9: Entering the interrupt cycle clears the enable flag, and a pulse on the enable-set input sets it again. While the flag is clear, the request input has no effect.
- R10: Read and write are never strobed in the same cycle. A read strobe presents the address in the same cycle, and the word is taken from read data in the next cycle. Write data is always the buffer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time unit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Read strobe; data is returned next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the read strobe |
| irq_req | input | 1 | Interrupt request, level |
| irq_en_set | input | 1 | Sets the interrupt enable flag |
| halted | output | 1 | High once a halt instruction has run |
| cyc_code | output | 2 | Current instruction cycle code |
| pc_o | output | 12 | Program counter |
| r1_o | output | 16 | Accumulator |

## Verification
Each instruction has a known cost in time units: 3 for fetch, 3 for indirect, 3 for add, 4 for increment-and-skip, 3 for branch-and-save, 1 for halt and 3 for an interrupt. The bench adds up these costs for each program and compares the total with the number of rising edges between reset release and the first cycle in which halted is seen high. A read address must be on the port in the same cycle as its strobe, so the first fetch address is sampled just after reset is released. Every memory write is matched, in order, against a queue of expected address, data and cycle-code items. These are sampled at the falling edge inside the unit that carries the write. Register values are compared only after halt, when they are frozen.

// File: rtl/uop_pkg.sv
// Shared types for the micro-sequenced core: cycle codes, opcodes and the
// control word that the step decoder hands to the sequencer and datapath.
package uop_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'b00,
        CYC_IND   = 2'b01,
        CYC_EXEC  = 2'b10,
        CYC_INT   = 2'b11
    } cyc_e;

    localparam logic [2:0] OPC_ADD  = 3'd0;
    localparam logic [2:0] OPC_ISZ  = 3'd1;
    localparam logic [2:0] OPC_BSA  = 3'd2;
    localparam logic [2:0] OPC_HALT = 3'd7;

    typedef enum logic [1:0] {MAR_KEEP, MAR_PC, MAR_IRA, MAR_SAVE} mar_src_e;
    typedef enum logic [1:0] {MBR_KEEP, MBR_MEM, MBR_PC, MBR_INC} mbr_src_e;
    typedef enum logic [2:0] {PC_KEEP, PC_INC, PC_ROUTINE, PC_IRA, PC_INC_Z} pc_op_e;

    typedef struct packed {
        mar_src_e mar;
        mbr_src_e mbr;
        pc_op_e   pc;
        logic     ir_ld;
        logic     ira_ld;
        logic     r1_add;
        logic     rd;
        logic     wr;
        logic     ie_clr;
        logic     last;
        logic     halt;
    } uop_ctl_t;

endpackage

// File: rtl/uop_decode.sv
// Step decoder: turns (cycle code, step, opcode) into one control word.
// Assumes the transfers grouped into each step do not conflict; an idle
// control word is produced whenever the core is not active.
module uop_decode
    import uop_pkg::*;
(
    input  cyc_e       cyc,
    input  logic [1:0] step,
    input  logic [2:0] opc,
    input  logic       active,
    output uop_ctl_t   ctl
);

    // Decode the transfer group for the current time unit.
    always_comb begin
        ctl = '0;
        if (active) begin
            unique case (cyc)
                CYC_FETCH: begin
                    case (step)
                        2'd0: begin ctl.mar = MAR_PC; ctl.rd = 1'b1; end
                        2'd1: begin ctl.mbr = MBR_MEM; ctl.pc = PC_INC; end
                        default: begin ctl.ir_ld = 1'b1; ctl.last = 1'b1; end
                    endcase
                end
                CYC_IND: begin
                    case (step)
                        2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                        2'd1: ctl.mbr = MBR_MEM;
                        default: begin ctl.ira_ld = 1'b1; ctl.last = 1'b1; end
                    endcase
                end
                CYC_INT: begin
                    case (step)
                        2'd0: begin ctl.mbr = MBR_PC; ctl.ie_clr = 1'b1; end
                        2'd1: begin ctl.mar = MAR_SAVE; ctl.pc = PC_ROUTINE; end
                        default: begin ctl.wr = 1'b1; ctl.last = 1'b1; end
                    endcase
                end
                CYC_EXEC: begin
                    case (opc)
                        OPC_ADD: begin
                            case (step)
                                2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                                2'd1: ctl.mbr = MBR_MEM;
                                default: begin ctl.r1_add = 1'b1; ctl.last = 1'b1; end
                            endcase
                        end
                        OPC_ISZ: begin
                            case (step)
                                2'd0: begin ctl.mar = MAR_IRA; ctl.rd = 1'b1; end
                                2'd1: ctl.mbr = MBR_MEM;
                                2'd2: ctl.mbr = MBR_INC;
                                default: begin
                                    ctl.wr = 1'b1; ctl.pc = PC_INC_Z; ctl.last = 1'b1;
                                end
                            endcase
                        end
                        OPC_BSA: begin
                            case (step)
                                2'd0: begin ctl.mar = MAR_IRA; ctl.mbr = MBR_PC; end
                                2'd1: begin ctl.wr = 1'b1; ctl.pc = PC_IRA; end
                                default: begin ctl.pc = PC_INC; ctl.last = 1'b1; end
                            endcase
                        end
                        OPC_HALT: ctl.halt = 1'b1;
                        // Unassigned opcodes retire after one unit with no transfer.
                        default: ctl.last = 1'b1;
                    endcase
                end
            endcase
        end
    end

endmodule

// File: rtl/uop_seq.sv
// Cycle sequencer: holds the 2-bit cycle code, the step counter and the
// halted flag. Assumes the decoder marks the final unit of each cycle.
module uop_seq
    import uop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       last,
    input  logic       halt,
    input  logic       ind_flag,
    input  logic       irq_take,
    output cyc_e       cyc,
    output logic [1:0] step,
    output logic       halted
);

    cyc_e cyc_nx;

    // Choose the cycle that follows the one now ending.
    always_comb begin
        unique case (cyc)
            CYC_FETCH: cyc_nx = ind_flag ? CYC_IND : CYC_EXEC;
            CYC_IND:   cyc_nx = CYC_EXEC;
            CYC_EXEC:  cyc_nx = irq_take ? CYC_INT : CYC_FETCH;
            default:   cyc_nx = CYC_FETCH;
        endcase
    end

    // Advance the step, change cycle at its last unit, or freeze on halt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc    <= CYC_FETCH;
            step   <= 2'd0;
            halted <= 1'b0;
        end else if (!halted) begin
            if (halt) begin
                halted <= 1'b1;
            end else if (last) begin
                cyc  <= cyc_nx;
                step <= 2'd0;
            end else begin
                step <= step + 2'd1;
            end
        end
    end

    // R2
    short_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != CYC_EXEC) |-> (step != 2'd3));

    // R3
    ind_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_IND && last && !halted) |=> (cyc == CYC_EXEC));

    // R8
    int_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_INT && last && !halted) |=> (cyc == CYC_FETCH && step == 2'd0));

endmodule

// File: rtl/uop_dp.sv
// Datapath: the PC, MAR, MBR, IR and accumulator, loaded as the control
// word asks. The memory address is MAR's incoming value, so a synchronous
// read launched with the MAR load returns in the next unit.
module uop_dp
    import uop_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12,
    parameter logic [AW-1:0] RST_PC       = 2,
    parameter logic [AW-1:0] SAVE_ADDR    = 0,
    parameter logic [AW-1:0] ROUTINE_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  uop_ctl_t      ctl,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mar_d,
    output logic [DW-1:0] mbr,
    output logic [DW-1:0] ir,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] r1
);

    localparam int PAD = DW - AW;
    localparam logic [AW-1:0] PC_ONE  = 1;
    localparam logic [DW-1:0] MBR_ONE = 1;

    logic [AW-1:0] mar;

    // Select the value MAR takes at the next edge (also the bus address).
    always_comb begin
        case (ctl.mar)
            MAR_PC:   mar_d = pc;
            MAR_IRA:  mar_d = ir[AW-1:0];
            MAR_SAVE: mar_d = SAVE_ADDR;
            default:  mar_d = mar;
        endcase
    end

    // Register transfers for one time unit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
            mbr <= '0;
            ir  <= '0;
            r1  <= '0;
            pc  <= RST_PC;
        end else begin
            mar <= mar_d;
            case (ctl.mbr)
                MBR_MEM: mbr <= mem_rdata;
                MBR_PC:  mbr <= {{PAD{1'b0}}, pc};
                MBR_INC: mbr <= mbr + MBR_ONE;
                default: ;
            endcase
            if (ctl.ir_ld)
                ir <= mbr;
            else if (ctl.ira_ld)
                ir[AW-1:0] <= mbr[AW-1:0];
            case (ctl.pc)
                PC_INC:     pc <= pc + PC_ONE;
                PC_ROUTINE: pc <= ROUTINE_ADDR;
                PC_IRA:     pc <= ir[AW-1:0];
                PC_INC_Z:   if (mbr == '0) pc <= pc + PC_ONE;
                default: ;
            endcase
            if (ctl.r1_add)
                r1 <= r1 + mbr;
        end
    end

endmodule

// File: rtl/uop_core.sv
// Top of the micro-sequenced core: ties the step decoder, sequencer and
// datapath together and keeps the interrupt enable flag. Assumes a word
// memory with one-cycle read latency and writes taken at the strobe edge.
module uop_core
    import uop_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 12,
    parameter logic [AW-1:0] RST_PC       = 2,
    parameter logic [AW-1:0] SAVE_ADDR    = 0,
    parameter logic [AW-1:0] ROUTINE_ADDR = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          irq_req,
    input  logic          irq_en_set,
    output logic          halted,
    output logic [1:0]    cyc_code,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] r1_o
);

    localparam int IND_POS = AW;
    localparam int OPC_LSB = AW + 1;

    uop_ctl_t      ctl;
    cyc_e          cyc;
    logic [1:0]    step;
    logic [DW-1:0] mbr;
    logic [DW-1:0] ir;
    logic          ie_q;
    logic          active;

    assign active = rst_n && !halted;

    uop_decode u_dec (
        .cyc    (cyc),
        .step   (step),
        .opc    (ir[DW-1:OPC_LSB]),
        .active (active),
        .ctl    (ctl)
    );

    uop_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .last     (ctl.last),
        .halt     (ctl.halt),
        .ind_flag (mbr[IND_POS]),
        .irq_take (irq_req && ie_q),
        .cyc      (cyc),
        .step     (step),
        .halted   (halted)
    );

    uop_dp #(
        .DW (DW), .AW (AW), .RST_PC (RST_PC),
        .SAVE_ADDR (SAVE_ADDR), .ROUTINE_ADDR (ROUTINE_ADDR)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar_d     (mem_addr),
        .mbr       (mbr),
        .ir        (ir),
        .pc        (pc_o),
        .r1        (r1_o)
    );

    // Interrupt enable: cleared on interrupt entry (wins), set by the input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (ctl.ie_clr)
            ie_q <= 1'b0;
        else if (irq_en_set)
            ie_q <= 1'b1;
    end

    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign mem_wdata = mbr;
    assign cyc_code  = cyc;

    // R10
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_o) && $stable(r1_o) && $stable(cyc_code) && !mem_rd && !mem_wr));

    // R9
    ie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_INT && step == 2'd0 && !halted) |=> !ie_q);

endmodule

// File: tb/tb_uop_core.sv
module tb_uop_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        irq_req, irq_en_set;
    logic        halted;
    logic [1:0]  cyc_code;
    logic [11:0] pc_o;
    logic [15:0] r1_o;

    always #10 clk = ~clk;  // 50 MHz

    uop_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_req(irq_req), .irq_en_set(irq_en_set), .halted(halted),
        .cyc_code(cyc_code), .pc_o(pc_o), .r1_o(r1_o)
    );

    // Memory model: load port for the bench, synchronous read, write at edge.
    logic [15:0] mem [0:4095];
    logic        ld_en;
    logic [11:0] ld_a;
    logic [15:0] ld_d;
    always @(posedge clk) begin
        if (ld_en) mem[ld_a] <= ld_d;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [11:0] a;
        logic [15:0] d;
        logic [1:0]  c;
        string       tag;
    } wr_t;
    wr_t exp_q[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [11:0] a, input logic [15:0] d,
                             input logic [1:0] c, input string tag);
        wr_t e;
        e.a = a; e.d = d; e.c = c; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: every write pops the next expected item and compares.
    always @(negedge clk) begin : mon
        wr_t e;
        if (rst_n && mem_wr) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected write addr", {20'd0, mem_addr}, 32'hFFFF_FFFF);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " write addr"}, {20'd0, mem_addr}, {20'd0, e.a});
                chk({e.tag, " write data"}, {16'd0, mem_wdata}, {16'd0, e.d});
                chk({e.tag, " cycle code"}, {30'd0, cyc_code}, {30'd0, e.c});
            end
        end
    end

    task automatic ld(input logic [11:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_a = a; ld_d = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic run_to_halt(output int cnt);
        cnt = 0;
        for (int i = 0; i < 2000; i++) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            irq_en_set = 1'b0;
            if (halted) break;
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 pc"}, {20'd0, pc_o}, 32'h2);
        chk({tag, " R1 acc"}, {16'd0, r1_o}, 32'h0);
        chk({tag, " R1 cycle code"}, {30'd0, cyc_code}, 32'h0);
        chk({tag, " R1 halted"}, {31'd0, halted}, 32'h0);
        chk({tag, " R1 strobes"}, {30'd0, mem_rd, mem_wr}, 32'h0);
    endtask

    initial begin : wdog
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int cnt;
        logic [11:0] pc_hold;
        logic [15:0] r1_hold;
        rst_n = 1'b0; irq_req = 1'b0; irq_en_set = 1'b0;
        ld_en = 1'b0; ld_a = '0; ld_d = '0;
        repeat (2) @(negedge clk);

        // Program A: enable never set, request held high (R9 ignored).
        ld(12'h002, 16'h0100);  // ADD 0x100
        ld(12'h003, 16'h1101);  // ADD indirect via 0x101
        ld(12'h004, 16'h2103);  // ISZ 0x103
        ld(12'h005, 16'h2103);  // ISZ 0x103 -> zero, skip
        ld(12'h006, 16'hE000);  // HALT (must be skipped)
        ld(12'h007, 16'h3104);  // ISZ indirect via 0x104
        ld(12'h008, 16'h4200);  // BSA 0x200
        ld(12'h201, 16'h0106);  // ADD 0x106 (wrap to zero)
        ld(12'h202, 16'h5107);  // BSA indirect via 0x107
        ld(12'h301, 16'hE000);  // HALT
        ld(12'h100, 16'h0005);
        ld(12'h101, 16'h0102);
        ld(12'h102, 16'h0007);
        ld(12'h103, 16'hFFFE);
        ld(12'h104, 16'h0105);
        ld(12'h105, 16'h0003);
        ld(12'h106, 16'hFFF4);
        ld(12'h107, 16'h0300);
        check_reset_state("start");

        expect_wr(12'h103, 16'hFFFF, 2'b10, "R5 isz nonzero");
        expect_wr(12'h103, 16'h0000, 2'b10, "R5 isz zero");
        expect_wr(12'h105, 16'h0004, 2'b10, "R3 R5 isz indirect");
        expect_wr(12'h200, 16'h0009, 2'b10, "R6 bsa save");
        expect_wr(12'h300, 16'h0203, 2'b10, "R3 R6 bsa indirect save");
        irq_req = 1'b1;
        rst_n = 1'b1;
        #1;
        chk("R10 first read strobe", {31'd0, mem_rd}, 32'h1);
        chk("R10 first read addr", {20'd0, mem_addr}, 32'h2);
        run_to_halt(cnt);
        chk("R2 R3 R4 R5 R6 R7 unit count A", cnt, 64);
        chk("R4 acc after wrap", {16'd0, r1_o}, 32'h0);
        chk("R6 pc after bsa and halt", {20'd0, pc_o}, 32'h302);
        chk("R7 halted", {31'd0, halted}, 32'h1);
        chk("R2 code in halt", {30'd0, cyc_code}, 32'h2);
        pc_hold = pc_o; r1_hold = r1_o;
        repeat (6) @(negedge clk);
        chk("R7 pc frozen", {20'd0, pc_o}, {20'd0, pc_hold});
        chk("R7 acc frozen", {16'd0, r1_o}, {16'd0, r1_hold});
        chk("R7 no read", {31'd0, mem_rd}, 32'h0);
        chk("R5 R6 writes all seen A", exp_q.size(), 0);

        // Program B: interrupt taken once, enable then cleared (R8, R9).
        rst_n = 1'b0;
        @(negedge clk);
        ld(12'h002, 16'h0100);  // ADD 0x100
        ld(12'h003, 16'hE000);  // HALT
        ld(12'h001, 16'h0110);  // service: ADD 0x110
        ld(12'h100, 16'h0005);
        ld(12'h110, 16'h0001);
        check_reset_state("after halt");
        expect_wr(12'h000, 16'h0003, 2'b11, "R8 save pc");
        irq_req = 1'b1;
        irq_en_set = 1'b1;
        rst_n = 1'b1;
        run_to_halt(cnt);
        chk("R8 R9 unit count B", cnt, 25);
        chk("R9 acc one service pass", {16'd0, r1_o}, 32'hB);
        chk("R8 pc after resume", {20'd0, pc_o}, 32'h4);
        chk("R8 writes all seen B", exp_q.size(), 0);

        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_reset_state("end");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule